// File: doc/BRIEF.md
# Sliding-Window LZ Byte Decompressor

This block rebuilds original bytes from a packed stream of literal and copy codewords. Compressed bytes arrive on a ready/valid port, and a last flag marks the final byte of a frame. The block decodes the stream into a 512-entry byte history and sends each reconstructed byte out on a second ready/valid port. Every byte it produces is also written into the history, so a later copy codeword can refer back to it.

Each frame must end with an end-marker codeword. The block removes the marker from the output, discards any padding and trailing bytes up to the last flag, and reports the frame as done. If the last byte arrives and the remaining bits do not contain a marker, the block reports an end error instead. The history is wiped before each frame. While it is being wiped, the input is held off.

Top module: `lz_window_decoder`

## Requirements
- R1: After reset, and after each frame ends, the block wipes every history entry to zero. During the wipe, which takes HIST_DEPTH cycles, in_ready stays low and no byte leaves. After reset, out_valid, done_o and end_err_o are low.
- R2: A codeword that starts with a 0 bit is a literal. It carries the next 8 bits as a byte, most significant bit first. The block emits that byte and stores it in the history.
- R3: A codeword that starts with a 1 bit and has a 4-bit length code L below 15 is a copy. After L comes a 9-bit displacement D. The block emits L+1 bytes, one per cycle. Each byte is read from history[(wp - D) mod 512], where wp is the write pointer, which advances after every byte. Copies may overlap the bytes they produce.
- R4: A codeword made of a 1 bit, length code 15 and 9 more bits is the end marker. It produces no output byte and gives a one-cycle pulse on done_o.
- R5: After the end marker, the block ignores the zero padding bits and every further input byte up to and including the one flagged last. None of them produces output.
- R6: If the last byte has been taken and the remaining bits hold no complete codeword, and no marker has been seen, the block gives a one-cycle pulse on end_err_o. done_o and end_err_o never pulse together.
- R7: A copy that reaches history positions not written in the current frame yields zero bytes. This holds even when an earlier frame wrote those positions.
- R8: While out_valid is high and out_ready is low, out_valid and out_data hold steady. No byte is lost or repeated.
- R9: Bits are taken from each input byte most significant first, and a codeword may straddle input bytes.
- R10: History addressing wraps modulo 512. Once a frame has produced more than 512 bytes, displacement 0 returns the byte written 512 positions earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Compressed input byte |
| in_valid | input | 1 | Input byte valid |
| in_last | input | 1 | Input byte is the final one of the frame |
| in_ready | output | 1 | Block accepts an input byte this cycle |
| out_data | output | 8 | Reconstructed byte |
| out_valid | output | 1 | Reconstructed byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| done_o | output | 1 | One-cycle pulse: end marker found |
| end_err_o | output | 1 | One-cycle pulse: frame ended without end marker |

## Verification
A bit buffer that loses its alignment turns every later codeword into the wrong one. The scoreboard then shows a wrong byte within a few outputs, and usually the wrong count of done_o or end_err_o pulses at the end of the frame. A write pointer or displacement that is off by one shows up only when a copy is decoded. The bench therefore uses overlapping copies, displacement 0 after a wrap, and copies into unwritten history. A wipe that is skipped or cut short shows as nonzero bytes in the first copy of a following frame, and as a wipe length that differs from 512 cycles.

// File: rtl/lzw_pkg.sv
package lzw_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_RUN   = 2'd1,
        ST_COPY  = 2'd2,
        ST_DRAIN = 2'd3
    } dec_state_e;

endpackage

// File: rtl/lzw_bitbuf.sv
module lzw_bitbuf #(
    parameter int BUF_W  = 22,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = $clog2(BUF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [CNT_W-1:0]  take_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [BUF_W-1:0]  bits_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              room_o
);

    localparam int ROOM_LIMIT = BUF_W - BYTE_W;

    typedef struct packed {
        logic [BUF_W-1:0] bits;
        logic [CNT_W-1:0] cnt;
    } bb_t;

    bb_t bb_d, bb_q;

    logic [BUF_W-1:0] shifted;
    logic [BUF_W-1:0] inserted;
    logic [CNT_W-1:0] cnt_left;

    always_comb begin
        shifted  = bb_q.bits << take_i;
        cnt_left = bb_q.cnt - take_i;
        inserted = {byte_i, {ROOM_LIMIT{1'b0}}} >> cnt_left;
        bb_d     = bb_q;
        if (flush_i) begin
            bb_d.bits = '0;
            bb_d.cnt  = '0;
        end else if (load_i) begin
            bb_d.bits = shifted | inserted;
            bb_d.cnt  = cnt_left + CNT_W'(BYTE_W);
        end else begin
            bb_d.bits = shifted;
            bb_d.cnt  = cnt_left;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bb_q <= '0;
        end else begin
            bb_q <= bb_d;
        end
    end

    assign bits_o = bb_q.bits;
    assign cnt_o  = bb_q.cnt;
    assign room_o = (bb_q.cnt <= CNT_W'(ROOM_LIMIT));

    // R9
    load_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !flush_i) |-> (bb_q.cnt <= CNT_W'(ROOM_LIMIT)));

    // R9
    take_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i <= bb_q.cnt);

    // R9
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bb_q.cnt <= CNT_W'(BUF_W));

endmodule

// File: rtl/lzw_history.sv
module lzw_history #(
    parameter int DEPTH  = 512,
    parameter int BYTE_W = 8,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [BYTE_W-1:0] rdata_o
);

    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/lz_window_decoder.sv
module lz_window_decoder
    import lzw_pkg::*;
#(
    parameter int HIST_DEPTH = 512,
    parameter int LEN_W      = 4,
    parameter int BYTE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              done_o,
    output logic              end_err_o
);

    localparam int AW       = $clog2(HIST_DEPTH);
    localparam int LIT_BITS = 1 + BYTE_W;
    localparam int CPY_BITS = 1 + LEN_W + AW;
    localparam int BUF_W    = CPY_BITS + BYTE_W;
    localparam int CNT_W    = $clog2(BUF_W + 1);

    typedef struct packed {
        dec_state_e        st;
        logic [AW-1:0]     wptr;
        logic [AW-1:0]     clr;
        logic [AW-1:0]     disp;
        logic [LEN_W-1:0]  rem;
        logic              last_seen;
        logic [BYTE_W-1:0] odata;
        logic              ovalid;
        logic              done;
        logic              err;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [BUF_W-1:0]  bb_bits;
    logic [CNT_W-1:0]  bb_cnt;
    logic              bb_room;
    logic [CNT_W-1:0]  take;
    logic              flush;
    logic              load;
    logic              accept;

    logic              h_we;
    logic [AW-1:0]     h_waddr;
    logic [BYTE_W-1:0] h_wdata;
    logic [AW-1:0]     h_raddr;
    logic [BYTE_W-1:0] h_rdata;

    logic              head_bit;
    logic [BYTE_W-1:0] lit_byte;
    logic [LEN_W-1:0]  len_code;
    logic [AW-1:0]     disp_code;
    logic              slot_free;
    logic              in_ready_c;

    assign head_bit  = bb_bits[BUF_W-1];
    assign lit_byte  = bb_bits[BUF_W-2 -: BYTE_W];
    assign len_code  = bb_bits[BUF_W-2 -: LEN_W];
    assign disp_code = bb_bits[BUF_W-2-LEN_W -: AW];
    assign h_raddr   = c_q.wptr - c_q.disp;

    always_comb begin
        slot_free  = !c_q.ovalid || out_ready;
        in_ready_c = ((c_q.st == ST_RUN || c_q.st == ST_COPY) && bb_room && !c_q.last_seen)
                     || (c_q.st == ST_DRAIN);
        accept     = in_valid && in_ready_c;
        load       = accept && (c_q.st != ST_DRAIN);

        c_d        = c_q;
        c_d.done   = 1'b0;
        c_d.err    = 1'b0;
        take       = '0;
        flush      = 1'b0;
        h_we       = 1'b0;
        h_waddr    = c_q.wptr;
        h_wdata    = '0;

        if (c_q.ovalid && out_ready) begin
            c_d.ovalid = 1'b0;
        end
        if (load && in_last) begin
            c_d.last_seen = 1'b1;
        end

        unique case (c_q.st)
            ST_CLEAR: begin
                flush         = 1'b1;
                h_we          = 1'b1;
                h_waddr       = c_q.clr;
                h_wdata       = '0;
                c_d.clr       = c_q.clr + 1'b1;
                c_d.last_seen = 1'b0;
                c_d.wptr      = '0;
                if (c_q.clr == AW'(HIST_DEPTH - 1)) begin
                    c_d.st  = ST_RUN;
                    c_d.clr = '0;
                end
            end

            ST_RUN: begin
                if (!head_bit && bb_cnt >= CNT_W'(LIT_BITS)) begin
                    if (slot_free) begin
                        take       = CNT_W'(LIT_BITS);
                        c_d.odata  = lit_byte;
                        c_d.ovalid = 1'b1;
                        h_we       = 1'b1;
                        h_wdata    = lit_byte;
                        c_d.wptr   = c_q.wptr + 1'b1;
                    end
                end else if (head_bit && bb_cnt >= CNT_W'(CPY_BITS)) begin
                    take = CNT_W'(CPY_BITS);
                    if (&len_code) begin
                        c_d.done = 1'b1;
                        c_d.clr  = '0;
                        if (c_q.last_seen || (load && in_last)) begin
                            c_d.st = ST_CLEAR;
                        end else begin
                            c_d.st = ST_DRAIN;
                        end
                    end else begin
                        c_d.disp = disp_code;
                        c_d.rem  = len_code + 1'b1;
                        c_d.st   = ST_COPY;
                    end
                end else if (c_q.last_seen) begin
                    c_d.err = 1'b1;
                    c_d.clr = '0;
                    c_d.st  = ST_CLEAR;
                end
            end

            ST_COPY: begin
                if (slot_free) begin
                    c_d.odata  = h_rdata;
                    c_d.ovalid = 1'b1;
                    h_we       = 1'b1;
                    h_wdata    = h_rdata;
                    c_d.wptr   = c_q.wptr + 1'b1;
                    c_d.rem    = c_q.rem - 1'b1;
                    if (c_q.rem == LEN_W'(1)) begin
                        c_d.st = ST_RUN;
                    end
                end
            end

            ST_DRAIN: begin
                if (accept && in_last) begin
                    c_d.clr = '0;
                    c_d.st  = ST_CLEAR;
                end
            end

            default: begin
                c_d.st = ST_CLEAR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_CLEAR;
        end else begin
            c_q <= c_d;
        end
    end

    lzw_bitbuf #(
        .BUF_W  (BUF_W),
        .BYTE_W (BYTE_W),
        .CNT_W  (CNT_W)
    ) bitbuf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush),
        .take_i  (take),
        .load_i  (load),
        .byte_i  (in_data),
        .bits_o  (bb_bits),
        .cnt_o   (bb_cnt),
        .room_o  (bb_room)
    );

    lzw_history #(
        .DEPTH  (HIST_DEPTH),
        .BYTE_W (BYTE_W),
        .AW     (AW)
    ) hist_i (
        .clk     (clk),
        .we_i    (h_we),
        .waddr_i (h_waddr),
        .wdata_i (h_wdata),
        .raddr_i (h_raddr),
        .rdata_o (h_rdata)
    );

    assign in_ready  = in_ready_c;
    assign out_data  = c_q.odata;
    assign out_valid = c_q.ovalid;
    assign done_o    = c_q.done;
    assign end_err_o = c_q.err;

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R1
    clear_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_CLEAR) |-> (!in_ready && !c_d.done && !c_d.err));

    // R5
    drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_DRAIN && !out_valid) |=> !out_valid);

    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && end_err_o));

    // R3
    copy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_COPY) |-> (c_q.rem != '0));

    // R4
    marker_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/lz_window_decoder_tb_top.sv
`timescale 1ns/1ps
module lz_window_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic       done_o;
    logic       end_err_o;

    always #2.5 clk = ~clk;

    lz_window_decoder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .done_o    (done_o),
        .end_err_o (end_err_o)
    );

    int         n_checks = 0;
    int         n_fail = 0;
    int         done_cnt = 0;
    int         err_cnt = 0;
    bit         stall_mode = 1'b0;
    bit         gap_mode = 1'b0;
    string      cur_req = "R2";
    logic [7:0] exp_q[$];
    bit         bitq[$];
    logic [7:0] mhist[512];
    int         mwp = 0;
    bit         prev_stall = 1'b0;
    logic [7:0] prev_data = '0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor and scoreboard, all sampling at the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_stall = 1'b0;
            out_ready  = 1'b0;
        end else begin
            if (prev_stall) begin
                // R8: a stalled byte holds steady
                check(out_valid && out_data == prev_data, "R8",
                      {out_valid, out_data}, {1'b1, prev_data});
            end
            if (done_o)    done_cnt++;
            if (end_err_o) err_cnt++;
            out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected byte", out_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(out_data == e, cur_req, out_data, e);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    task automatic put_bits(input int value, input int n);
        for (int i = n - 1; i >= 0; i--) bitq.push_back(value[i]);
    endtask

    task automatic new_frame(input string req);
        cur_req = req;
        bitq.delete();
        for (int i = 0; i < 512; i++) mhist[i] = 8'h00;
        mwp = 0;
    endtask

    task automatic lit(input logic [7:0] b);
        put_bits(0, 1);
        put_bits(b, 8);
        exp_q.push_back(b);
        mhist[mwp & 511] = b;
        mwp++;
    endtask

    task automatic cpy(input int len, input int disp);
        logic [7:0] b;
        put_bits(1, 1);
        put_bits(len - 1, 4);
        put_bits(disp, 9);
        for (int i = 0; i < len; i++) begin
            b = mhist[(mwp - disp) & 511];
            exp_q.push_back(b);
            mhist[mwp & 511] = b;
            mwp++;
        end
    endtask

    task automatic drive_byte(input logic [7:0] b, input bit last);
        in_data  = b;
        in_valid = 1'b1;
        in_last  = last;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (gap_mode) repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    // Ends the frame, sends it and checks how it finished.
    task automatic end_frame(input bit marker, input int trail, input string req);
        int         d0;
        int         e0;
        int         nbytes;
        int         waited;
        logic [7:0] bytes[$];
        d0 = done_cnt;
        e0 = err_cnt;
        if (marker) begin
            put_bits(1, 1);
            put_bits(15, 4);
            put_bits(0, 9);
        end
        while ((bitq.size() % 8) != 0) bitq.push_back(1'b0);
        nbytes = bitq.size() / 8;
        for (int k = 0; k < nbytes; k++) begin
            logic [7:0] v;
            for (int j = 0; j < 8; j++) v[7 - j] = bitq[k * 8 + j];
            bytes.push_back(v);
        end
        for (int t = 0; t < trail; t++) bytes.push_back(8'hA5 ^ 8'(t * 37));
        while (!in_ready) @(negedge clk);
        for (int k = 0; k < bytes.size(); k++) drive_byte(bytes[k], k == bytes.size() - 1);
        waited = 0;
        while ((exp_q.size() != 0 || (done_cnt + err_cnt) == (d0 + e0)) && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        repeat (20) @(negedge clk);
        check(done_cnt - d0 == int'(marker), req, done_cnt - d0, int'(marker));
        check(err_cnt - e0 == int'(!marker), req, err_cnt - e0, int'(!marker));
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and wipe length
        check(!out_valid && !done_o && !end_err_o, "R1",
              {out_valid, done_o, end_err_o}, 0);
        cyc = 0;
        while (!in_ready && cyc < 1000) begin
            check(!out_valid, "R1", out_valid, 0);
            @(negedge clk);
            cyc++;
        end
        check(cyc >= 510 && cyc <= 514, "R1", cyc, 512);

        // R2 / R9: literals straddling byte boundaries
        new_frame("R2");
        lit(8'h41); lit(8'h42); lit(8'hC3); lit(8'h00); lit(8'hFF);
        end_frame(1'b1, 0, "R2");

        // R3: overlapping and longer copies
        new_frame("R3");
        lit(8'h10); lit(8'h20);
        cpy(5, 2);
        lit(8'h7E);
        cpy(15, 3);
        cpy(1, 1);
        end_frame(1'b1, 0, "R3");

        // R7: copy into history never written this frame
        new_frame("R7");
        lit(8'h99);
        cpy(4, 100);
        end_frame(1'b1, 0, "R7");
        new_frame("R7");
        cpy(3, 1);
        lit(8'h55);
        cpy(2, 2);
        end_frame(1'b1, 0, "R7");

        // R4: frame with only the marker
        new_frame("R4");
        end_frame(1'b1, 0, "R4");

        // R5: bytes after the marker are ignored
        new_frame("R5");
        lit(8'h31); lit(8'h32);
        end_frame(1'b1, 3, "R5");
        new_frame("R5");
        lit(8'h33);
        end_frame(1'b1, 0, "R5");

        // R6: missing marker
        new_frame("R6");
        lit(8'h01); lit(8'h02); lit(8'h03);
        end_frame(1'b0, 0, "R6");
        new_frame("R6");
        lit(8'hE0);
        cpy(6, 1);
        end_frame(1'b0, 0, "R6");

        // R8: output backpressure and input gaps
        stall_mode = 1'b1;
        gap_mode   = 1'b1;
        new_frame("R8");
        for (int i = 0; i < 12; i++) lit(8'(i * 29 + 3));
        cpy(15, 7);
        cpy(9, 0);
        end_frame(1'b1, 2, "R8");

        // R10: wrap of the history pointer
        new_frame("R10");
        for (int i = 0; i < 600; i++) lit(8'(i ^ (i >> 3)));
        cpy(4, 0);
        cpy(6, 511);
        cpy(3, 300);
        end_frame(1'b1, 0, "R10");

        // R3 / R9: mixed random codewords
        new_frame("R3");
        for (int i = 0; i < 80; i++) begin
            if ($urandom_range(0, 1) == 0) lit(8'($urandom));
            else cpy($urandom_range(1, 15), $urandom_range(0, 511));
        end
        end_frame(1'b1, 1, "R3");

        stall_mode = 1'b0;
        gap_mode   = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule